// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Color Selector

This block forms one output color per clock for a framebuffer that mixes two pixel depths. Each cycle it takes three words for the same pixel: an 8-bit palette index, a 32-bit direct-color word and a 32-bit control word. A mode code in the top byte of the control word decides how that pixel is colored. The pixel either takes its 24-bit color straight from the direct word, or takes the color stored in an internal 256-entry palette at the given index.

There is no valid or ready handshake. A new pixel is accepted on every clock, and its color appears on the outputs exactly one clock later, with a flag that says which path produced it. The palette is written through a separate write port. A strap-like input forces every pixel onto the palette path, for configurations that carry only the 8-bit plane.

Top module: `pxsel_top`

## Requirements
- R1: While reset is asserted, the red, green and blue outputs are 0x00 and the direct flag is 0.
- R2: When bits [31:24] of the control word equal 0x03 and the force input is low, the output one clock later is the direct word's bits [23:16] on red, [15:8] on green and [7:0] on blue.
- R3: In direct mode, bits [31:24] of the direct word have no effect on the output color.
- R4: For any control code other than 0x03, the output one clock later is the palette entry at the index input. The low 24 bits of the control word have no effect.
- R5: The direct flag is 1 one clock after a pixel that uses the direct path, and 0 one clock after a pixel that uses the palette path.
- R6: While the force input is high, every pixel uses the palette path, even when its code is 0x03.
- R7: Reset sets every palette entry to black (0x000000), except entry 255, which becomes white (0xFFFFFF).
- R8: A palette write lands at the clock edge. A pixel presented in the same cycle as a write to its own index sees the old entry, and pixels presented later see the new entry.
- R9: Latency is exactly one clock. Pixels presented on consecutive cycles each appear on the outputs on the cycle after their own, with no gap and no mixing between neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| force_indexed | input | 1 | High forces the palette path for every pixel |
| pix_index_i | input | 8 | Palette index of the current pixel |
| pix_direct_i | input | 32 | Direct-color word; bits [23:0] hold the RGB |
| pix_ctrl_i | input | 32 | Control word; bits [31:24] hold the mode code |
| pal_we_i | input | 1 | Palette write enable |
| pal_addr_i | input | 8 | Palette entry to write |
| pal_data_i | input | 24 | Palette color to write, red in [23:16], green in [15:8], blue in [7:0] |
| out_red_o | output | 8 | Red of the pixel from the previous cycle |
| out_green_o | output | 8 | Green of the pixel from the previous cycle |
| out_blue_o | output | 8 | Blue of the pixel from the previous cycle |
| out_direct_o | output | 1 | 1 when that pixel took the direct path |

## Verification
The clocked properties assume that every input is driven to a known level on every cycle once reset is released, because each cycle is treated as a real pixel with no valid qualifier. The indexed-path property compares the output against the palette's read port, which is brought out as a named wire. It therefore assumes that nothing but the write port changes the palette. The bench drives all inputs from time zero, changes them only two nanoseconds after a rising edge, and keeps the pixel inputs at defined values during palette loading and reset, so every cycle the properties see is well defined.

// File: rtl/pxsel_pkg.sv
package pxsel_pkg;

  localparam int CH_W    = 8;
  localparam int WORD_W  = 32;
  localparam int CODE_LSB = 24;
  localparam int CODE_W  = WORD_W - CODE_LSB;

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] green;
    logic [CH_W-1:0] blue;
  } rgb_t;

  localparam int RGB_W = $bits(rgb_t);

  // mode code sits in the top byte of the control word
  function automatic logic [CODE_W-1:0] mode_code(input logic [WORD_W-1:0] ctrl);
    return ctrl[WORD_W-1:CODE_LSB];
  endfunction

  // direct word: top byte dropped, rest split into channels
  function automatic rgb_t unpack_direct(input logic [WORD_W-1:0] word);
    rgb_t c;
    c.red   = word[3*CH_W-1:2*CH_W];
    c.green = word[2*CH_W-1:CH_W];
    c.blue  = word[CH_W-1:0];
    return c;
  endfunction

  // power-on palette: black everywhere, white in the last entry
  function automatic rgb_t pal_reset_value(input int entry, input int last);
    rgb_t c;
    c = (entry == last) ? '1 : '0;
    return c;
  endfunction

endpackage

// File: rtl/pxsel_palette.sv
module pxsel_palette
  import pxsel_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  rgb_t             wdata,
  input  logic [IDX_W-1:0] raddr,
  output rgb_t             rdata
);
  localparam int DEPTH = 1 << IDX_W;

  rgb_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        mem[e] <= pal_reset_value(e, DEPTH - 1);
      end
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // asynchronous read: a same-cycle write is not yet visible
  assign rdata = mem[raddr];

endmodule

// File: rtl/pxsel_decode.sv
module pxsel_decode
  import pxsel_pkg::*;
#(
  parameter logic [CODE_W-1:0] DIRECT_CODE = 8'h03
) (
  input  logic [WORD_W-1:0] ctrl_word,
  input  logic [WORD_W-1:0] direct_word,
  input  logic              force_indexed,
  input  rgb_t              pal_rgb,
  output logic              use_direct,
  output rgb_t              sel_rgb
);
  logic code_hit;

  always_comb begin
    code_hit   = (mode_code(ctrl_word) == DIRECT_CODE);
    use_direct = code_hit && !force_indexed;
    sel_rgb    = use_direct ? unpack_direct(direct_word) : pal_rgb;
  end

endmodule

// File: rtl/pxsel_outreg.sv
module pxsel_outreg
  import pxsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  rgb_t d_rgb,
  input  logic d_direct,
  output rgb_t q_rgb,
  output logic q_direct
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rgb    <= '0;
      q_direct <= 1'b0;
    end else begin
      q_rgb    <= d_rgb;
      q_direct <= d_direct;
    end
  end

endmodule

// File: rtl/pxsel_top.sv
module pxsel_top
  import pxsel_pkg::*;
#(
  parameter int                IDX_W       = 8,
  parameter logic [CODE_W-1:0] DIRECT_CODE = 8'h03
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 force_indexed,
  input  logic [IDX_W-1:0]     pix_index_i,
  input  logic [WORD_W-1:0]    pix_direct_i,
  input  logic [WORD_W-1:0]    pix_ctrl_i,
  input  logic                 pal_we_i,
  input  logic [IDX_W-1:0]     pal_addr_i,
  input  logic [RGB_W-1:0]     pal_data_i,
  output logic [CH_W-1:0]      out_red_o,
  output logic [CH_W-1:0]      out_green_o,
  output logic [CH_W-1:0]      out_blue_o,
  output logic                 out_direct_o
);
  rgb_t        pal_rd_rgb;
  logic [RGB_W-1:0] pal_rd_flat;
  logic        sel_direct;
  rgb_t        sel_rgb;
  rgb_t        q_rgb;

  pxsel_palette #(.IDX_W(IDX_W)) u_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pal_we_i),
    .waddr (pal_addr_i),
    .wdata (rgb_t'(pal_data_i)),
    .raddr (pix_index_i),
    .rdata (pal_rd_rgb)
  );

  assign pal_rd_flat = pal_rd_rgb;

  pxsel_decode #(.DIRECT_CODE(DIRECT_CODE)) u_dec (
    .ctrl_word     (pix_ctrl_i),
    .direct_word   (pix_direct_i),
    .force_indexed (force_indexed),
    .pal_rgb       (pal_rd_rgb),
    .use_direct    (sel_direct),
    .sel_rgb       (sel_rgb)
  );

  pxsel_outreg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_rgb    (sel_rgb),
    .d_direct (sel_direct),
    .q_rgb    (q_rgb),
    .q_direct (out_direct_o)
  );

  assign out_red_o   = q_rgb.red;
  assign out_green_o = q_rgb.green;
  assign out_blue_o  = q_rgb.blue;

endmodule

// File: rtl/pxsel_chk.sv
module pxsel_chk #(
  parameter logic [7:0] DIRECT_CODE = 8'h03
) (
  input logic        clk,
  input logic        rst_n,
  input logic        force_indexed,
  input logic [31:0] pix_direct_i,
  input logic [31:0] pix_ctrl_i,
  input logic [23:0] lookup_rgb,
  input logic [7:0]  out_red_o,
  input logic [7:0]  out_green_o,
  input logic [7:0]  out_blue_o,
  input logic        out_direct_o
);
  logic [23:0] out_rgb;
  logic        code_is_direct;
  assign out_rgb        = {out_red_o, out_green_o, out_blue_o};
  assign code_is_direct = (pix_ctrl_i[31:24] == DIRECT_CODE);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (out_rgb == 24'h0 && !out_direct_o)); // R1

  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (code_is_direct && !force_indexed) |=>
      (out_direct_o && out_rgb == $past(pix_direct_i[23:0]))); // R2

  AST_INDEXED_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    !(code_is_direct && !force_indexed) |=> (out_rgb == $past(lookup_rgb))); // R4

  AST_OTHER_CODE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !code_is_direct |=> !out_direct_o); // R5

  AST_FORCE_INDEXED: assert property (@(posedge clk) disable iff (!rst_n)
    force_indexed |=> !out_direct_o); // R6

endmodule

bind pxsel_top pxsel_chk #(.DIRECT_CODE(DIRECT_CODE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .force_indexed (force_indexed),
  .pix_direct_i  (pix_direct_i),
  .pix_ctrl_i    (pix_ctrl_i),
  .lookup_rgb    (pal_rd_flat),
  .out_red_o     (out_red_o),
  .out_green_o   (out_green_o),
  .out_blue_o    (out_blue_o),
  .out_direct_o  (out_direct_o)
);

// File: tb/tb_pxsel_top.sv
module tb_pxsel_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        force_indexed = 1'b0;
  logic [7:0]  pix_index_i = '0;
  logic [31:0] pix_direct_i = '0;
  logic [31:0] pix_ctrl_i = '0;
  logic        pal_we_i = 1'b0;
  logic [7:0]  pal_addr_i = '0;
  logic [23:0] pal_data_i = '0;
  logic [7:0]  out_red_o, out_green_o, out_blue_o;
  logic        out_direct_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #4 clk = ~clk;  // 125 MHz

  pxsel_top dut (
    .clk(clk), .rst_n(rst_n), .force_indexed(force_indexed),
    .pix_index_i(pix_index_i), .pix_direct_i(pix_direct_i), .pix_ctrl_i(pix_ctrl_i),
    .pal_we_i(pal_we_i), .pal_addr_i(pal_addr_i), .pal_data_i(pal_data_i),
    .out_red_o(out_red_o), .out_green_o(out_green_o), .out_blue_o(out_blue_o),
    .out_direct_o(out_direct_o)
  );

  // bench palette pattern: red = index, green = inverted index, blue = index xor 0x5A
  function automatic logic [23:0] tb_pal(input logic [7:0] i);
    return {i, ~i, i ^ 8'h5A};
  endfunction

  // {force, index, direct, ctrl, expected rgb, expected flag}
  typedef struct packed {
    logic        frc;
    logic [7:0]  idx;
    logic [31:0] dir;
    logic [31:0] ctl;
    logic [23:0] exp_rgb;
    logic        exp_dir;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h10, 32'hAA123456, 32'h03000000, 24'h123456, 1'b1}, // R2 R3
    '{1'b0, 8'h10, 32'h00ABCDEF, 32'h03FFFFFF, 24'hABCDEF, 1'b1}, // R2
    '{1'b0, 8'h10, 32'h00ABCDEF, 32'h02000000, 24'h10EF4A, 1'b0}, // R4
    '{1'b0, 8'h00, 32'h11223344, 32'h00000003, 24'h00FF5A, 1'b0}, // R4
    '{1'b0, 8'hFF, 32'h00000000, 32'h83000000, 24'hFF00A5, 1'b0}, // R4 R5
    '{1'b0, 8'h3C, 32'h00C0FFEE, 32'h13000000, 24'h3CC366, 1'b0}, // R4
    '{1'b1, 8'h3C, 32'h00C0FFEE, 32'h03000000, 24'h3CC366, 1'b0}, // R6
    '{1'b1, 8'h81, 32'h00000000, 32'h03123456, 24'h817EDB, 1'b0}, // R6
    '{1'b0, 8'h81, 32'hFF000000, 32'h03ABCDEF, 24'h000000, 1'b1}, // R3
    '{1'b0, 8'h7F, 32'h00FFFFFF, 32'h03000001, 24'hFFFFFF, 1'b1}  // R5
  };

  task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual rgb/flag %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [24:0] got();
    return {out_red_o, out_green_o, out_blue_o, out_direct_o};
  endfunction

  task automatic pixel(input logic frc, input logic [7:0] idx,
                       input logic [31:0] dir, input logic [31:0] ctl);
    force_indexed = frc; pix_index_i = idx; pix_direct_i = dir; pix_ctrl_i = ctl;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    // R1: outputs clear during reset
    pixel(1'b0, 8'h00, 32'h00112233, 32'h03000000);
    tick(); tick();
    check("R1 reset outputs", got(), 25'h0);
    rst_n = 1'b1;

    // R7: default palette, index 0 black and index 255 white
    pixel(1'b0, 8'h00, 32'h0, 32'h0);
    tick();
    check("R7 entry 0 black", got(), {24'h000000, 1'b0});
    pixel(1'b0, 8'hFF, 32'h0, 32'h0);
    tick();
    check("R7 entry 255 white", got(), {24'hFFFFFF, 1'b0});

    // load the whole palette
    pixel(1'b0, 8'h00, 32'h0, 32'h0);
    for (int i = 0; i < 256; i++) begin
      pal_we_i = 1'b1; pal_addr_i = 8'(i); pal_data_i = tb_pal(8'(i));
      tick();
    end
    pal_we_i = 1'b0;

    // R9: table walked back to back, each result one clock later
    for (int v = 0; v < NV; v++) begin
      pixel(VECS[v].frc, VECS[v].idx, VECS[v].dir, VECS[v].ctl);
      tick();
      check($sformatf("R9 vector %0d (R2/R3/R4/R5/R6)", v), got(),
            {VECS[v].exp_rgb, VECS[v].exp_dir});
    end

    // R8: write and read of the same entry in one cycle sees the old color
    pal_we_i = 1'b1; pal_addr_i = 8'h20; pal_data_i = 24'h445566;
    pixel(1'b0, 8'h20, 32'h0, 32'h01000000);
    tick();
    pal_we_i = 1'b0;
    check("R8 same-cycle old entry", got(), {tb_pal(8'h20), 1'b0});
    tick();
    check("R8 next-cycle new entry", got(), {24'h445566, 1'b0});

    // R1 and R7: reset mid-run clears outputs and restores palette defaults
    pixel(1'b0, 8'h10, 32'h00FFFFFF, 32'h03000000);
    tick();
    rst_n = 1'b0;
    #1;
    check("R1 reset mid-run", got(), 25'h0);
    tick();
    rst_n = 1'b1;
    pixel(1'b0, 8'h10, 32'h0, 32'h0);
    tick();
    check("R7 entry 16 back to black", got(), {24'h000000, 1'b0});
    pixel(1'b0, 8'hFF, 32'h0, 32'h0);
    tick();
    check("R7 entry 255 back to white", got(), {24'hFFFFFF, 1'b0});

    finish_run();
  end

endmodule